// File: doc/BRIEF.md
# Soft Interrupt Level Encoder

This block turns a vector of pending software interrupt requests into a single 4-bit interrupt level. The level is meant for whatever logic decides whether an interrupt is taken. Only the low 17 bits of the input word carry requests. Two of those bits, the lowest (bit 0) and bit 16, are "top priority" requests: when either is set, the level is forced to 14 whatever else is pending. In all other cases the block looks for the most significant request among bits 15 down to 1. The level it reports is one less than that bit position.

The result is captured in a register on the rising clock edge. A companion any-pending flag tells a real level 0, which comes from bit 1 alone, apart from an idle vector. The bits of the input word above bit 16 are ignored. The block does not compare the level against a processor priority and does not raise traps.

Top module: `soft_irq_level_enc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge sets `level_o` to 0 and `any_o` to 0, whatever the input vector is.
- R2: If bit 0 or bit 16 of `pend_vec` is set, the following edge sets `level_o` to 14, whatever the other bits are.
- R3: If bits 0 and 16 are both clear and the highest set bit among positions 1 to 15 is at position p, the following edge sets `level_o` to p − 1.
- R4: If none of bits 0 to 16 is set, the following edge sets `level_o` to 0 and `any_o` to 0.
- R5: Bits 17 and above of `pend_vec` have no effect on `level_o` or `any_o`.
- R6: `any_o` becomes 1 at the edge after any of bits 0 to 16 is set. A vector with only bit 1 set therefore gives level 0 with `any_o` at 1.
- R7: Both outputs change only at a rising clock edge, and there they reflect the input sampled at that edge. A change of input between edges has no effect until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_vec | input | IN_W (64) | Pending request word; only bits 0 to 16 are used |
| level_o | output | 4 | Registered highest pending level, 0 to 14 |
| any_o | output | 1 | Registered flag: at least one of bits 0 to 16 was set |

## Verification
The top-priority override and the ordinary priority scan can both apply to the same vector. This happens when bit 0 or bit 16 is set together with any of bits 1 to 15. The bench provokes the overlap with random vectors that keep the override bits and with directed vectors that set bit 15 next to an override bit. It expects level 14 in every such case, because the override must win over the scan result. The same overlap arises with reset: the bench also drives an override vector while reset is low and expects level 0 and a clear flag.

// File: rtl/sirq_pkg.sv
// Package: shared constants and types for the soft interrupt level encoder.
// Assumes a fixed 17-bit request field inside a wider input word.
package sirq_pkg;
    localparam int SIG_BITS  = 17;  // significant request bits
    localparam int FORCE_LO  = 0;   // override bit, low end
    localparam int FORCE_HI  = 16;  // override bit, high end
    localparam int SCAN_LO   = 1;   // lowest scanned position
    localparam int SCAN_HI   = 15;  // highest scanned position
    localparam int LVL_W     = 4;   // level width
    localparam int TOP_LEVEL = 14;  // level forced by override bits

    typedef logic [LVL_W-1:0] level_t;
endpackage

// File: rtl/sirq_front.sv
// Module: sirq_front
// Picks the significant request bits out of the input word. Flags an
// override request and any request at all. Assumes IN_W >= SIG_BITS.
// Bits above the request field are deliberately dropped.
module sirq_front
    import sirq_pkg::*;
#(
    parameter int IN_W = 64
) (
    input  logic [IN_W-1:0]     vec_i,
    output logic [SCAN_HI:SCAN_LO] scan_o,
    output logic                force_o,
    output logic                any_o
);
    logic [SIG_BITS-1:0] sig;

    // Purpose: keep only the request field.
    assign sig = vec_i[SIG_BITS-1:0];

    // Purpose: drop bits above the request field.
    generate
        if (IN_W > SIG_BITS) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^vec_i[IN_W-1:SIG_BITS];
        end
    endgenerate

    // Purpose: split the request field into override and scanned parts.
    always_comb begin
        force_o = sig[FORCE_LO] | sig[FORCE_HI];
        scan_o  = sig[SCAN_HI:SCAN_LO];
        any_o   = |sig;
    end
endmodule

// File: rtl/sirq_prio_scan.sv
// Module: sirq_prio_scan
// Finds the most significant set bit among positions SCAN_LO..SCAN_HI.
// Reports that position minus one as a level. Builds a one-hot grant
// from a chain of "nothing higher" signals and OR-encodes it.
// Assumes the caller handles the override bits.
module sirq_prio_scan
    import sirq_pkg::*;
(
    input  logic [SCAN_HI:SCAN_LO] req_i,
    output level_t                 lvl_o,
    output logic                   hit_o
);
    logic [SCAN_HI+1:SCAN_LO] none_above;
    logic [SCAN_HI:SCAN_LO]   grant;

    // Purpose: seed the chain above the top scanned bit.
    assign none_above[SCAN_HI+1] = 1'b1;

    // Purpose: one stage per position, granting the highest request.
    generate
        for (genvar p = SCAN_HI; p >= SCAN_LO; p--) begin : g_pos
            assign grant[p]      = req_i[p] & none_above[p+1];
            assign none_above[p] = none_above[p+1] & ~req_i[p];
        end
    endgenerate

    // Purpose: encode the one-hot grant into a level (position minus one).
    always_comb begin
        lvl_o = '0;
        for (int p = SCAN_LO; p <= SCAN_HI; p++) begin
            if (grant[p]) begin
                lvl_o = lvl_o | level_t'(p - 1);
            end
        end
        hit_o = ~none_above[SCAN_LO];
    end
endmodule

// File: rtl/sirq_level_reg.sv
// Module: sirq_level_reg
// Output register for the level and the any-pending flag.
// Reset is synchronous and active low, and clears both.
module sirq_level_reg
    import sirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  level_t lvl_d,
    input  logic   any_d,
    output level_t lvl_q,
    output logic   any_q
);
    // Purpose: capture the next level and flag at each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            any_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
            any_q <= any_d;
        end
    end
endmodule

// File: rtl/soft_irq_level_enc.sv
// Module: soft_irq_level_enc (top)
// Registered priority encoder for a software interrupt request word.
// An override bit forces TOP_LEVEL; otherwise the highest scanned request
// at position p gives level p-1; with no request the level is 0.
// Assumes IN_W >= 17 and one clock domain.
module soft_irq_level_enc
    import sirq_pkg::*;
#(
    parameter int IN_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] pend_vec,
    output logic [LVL_W-1:0] level_o,
    output logic            any_o
);
    logic [SCAN_HI:SCAN_LO] scan_bits;
    logic                   force_req;
    logic                   any_req;
    level_t                 scan_lvl;
    logic                   scan_hit;
    level_t                 next_lvl;
    level_t                 lvl_q;
    logic                   any_q;

    sirq_front #(.IN_W(IN_W)) u_front (
        .vec_i   (pend_vec),
        .scan_o  (scan_bits),
        .force_o (force_req),
        .any_o   (any_req)
    );

    sirq_prio_scan u_scan (
        .req_i (scan_bits),
        .lvl_o (scan_lvl),
        .hit_o (scan_hit)
    );

    // Purpose: the override wins over the scan, and idle gives 0.
    always_comb begin
        if (force_req)     next_lvl = level_t'(TOP_LEVEL);
        else if (scan_hit) next_lvl = scan_lvl;
        else               next_lvl = '0;
    end

    sirq_level_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_d (next_lvl),
        .any_d (any_req),
        .lvl_q (lvl_q),
        .any_q (any_q)
    );

    // Purpose: drive the ports from the output register.
    assign level_o = lvl_q;
    assign any_o   = any_q;
endmodule

// File: rtl/sirq_level_chk.sv
// Module: sirq_level_chk
// Property checker bound to soft_irq_level_enc. It watches only the
// ports and relates the input at one edge to the outputs after it.
module sirq_level_chk
    import sirq_pkg::*;
#(
    parameter int IN_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IN_W-1:0]  pend_vec,
    input logic [LVL_W-1:0] level_o,
    input logic             any_o
);
    logic rst_seen;

    // Purpose: remember whether reset was low at the previous edge.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // Purpose: outputs are clear after an edge taken in reset (R1).
    always @(posedge clk) begin
        if (rst_seen === 1'b1) begin
            a_r1_reset_clear: assert (level_o == '0 && any_o == 1'b0);
        end
    end

    a_r2_force_top: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec[FORCE_LO] || pend_vec[FORCE_HI]) |=> level_o == LVL_W'(TOP_LEVEL));

    a_r3_bit15_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_vec[FORCE_LO] && !pend_vec[FORCE_HI] && pend_vec[SCAN_HI])
        |=> level_o == LVL_W'(SCAN_HI - 1));

    a_r3_range: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LVL_W'(TOP_LEVEL));

    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend_vec[SIG_BITS-1:0]) |=> (level_o == '0 && !any_o));

    a_r6_any_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_vec[SIG_BITS-1:0]) |=> any_o);
endmodule

bind soft_irq_level_enc sirq_level_chk #(.IN_W(IN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_vec (pend_vec),
    .level_o  (level_o),
    .any_o    (any_o)
);

// File: tb/soft_irq_level_enc_test.sv
// Scoreboard bench: a driver pushes the expected result for each vector.
// A monitor pops and compares it just after the edge that registers it.
module soft_irq_level_enc_test;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W       = 64;

    typedef struct {
        logic [3:0] lvl;
        logic       any;
        string      req;
        logic [IN_W-1:0] vec;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [IN_W-1:0] pend_vec = '0;
    logic [3:0]      level_o;
    logic            any_o;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    soft_irq_level_enc #(.IN_W(IN_W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_vec (pend_vec),
        .level_o  (level_o),
        .any_o    (any_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model written from the requirements.
    function automatic logic [3:0] model_lvl(logic [IN_W-1:0] v);
        if (v[0] || v[16]) return 4'd14;
        for (int p = 15; p >= 1; p--) if (v[p]) return 4'(p - 1);
        return 4'd0;
    endfunction

    function automatic logic model_any(logic [IN_W-1:0] v);
        return |v[16:0];
    endfunction

    task automatic check(string req, logic [3:0] al, logic aa,
                         logic [3:0] el, logic ea);
        n_checks++;
        if (al !== el || aa !== ea) begin
            n_fail++;
            $display("FAIL %s: actual level=%0d any=%0b expected level=%0d any=%0b",
                     req, al, aa, el, ea);
        end
    endtask

    // Driver: apply one vector in normal operation and push its expectation.
    task automatic apply(logic [IN_W-1:0] v, string req);
        exp_t e;
        @(negedge clk);
        rst_n    = 1'b1;
        pend_vec = v;
        e.lvl = model_lvl(v);
        e.any = model_any(v);
        e.req = req;
        e.vec = v;
        sb.push_back(e);
    endtask

    // Driver: apply a vector while reset is low; expect cleared outputs (R1).
    task automatic apply_in_reset(logic [IN_W-1:0] v);
        exp_t e;
        @(negedge clk);
        rst_n    = 1'b0;
        pend_vec = v;
        e.lvl = 4'd0;
        e.any = 1'b0;
        e.req = "R1";
        e.vec = v;
        sb.push_back(e);
    endtask

    // Monitor: compare just after each edge against the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, level_o, any_o, e.lvl, e.any);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7: watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [IN_W-1:0] v;
        // R1: outputs clear after edges taken in reset.
        repeat (3) @(posedge clk);
        #1;
        check("R1", level_o, any_o, 4'd0, 1'b0);

        // R4: idle vector.
        apply('0, "R4");

        // Single-bit sweep over the whole word: R2, R3, R5.
        for (int i = 0; i < IN_W; i++) begin
            v = '0;
            v[i] = 1'b1;
            if (i == 0 || i == 16) apply(v, "R2");
            else if (i < 16)       apply(v, "R3");
            else                   apply(v, "R5");
        end

        // R6: bit 1 alone gives a real level 0 with the flag set.
        apply(64'h2, "R6");
        // R4: nothing in the field, garbage above it (R5 as well).
        apply(64'hFFFF_FFFF_FFFE_0000, "R4");
        // R5: upper garbage must not disturb a scanned level.
        apply(64'hABCD_0000_0002_0020, "R5");
        // R2: override together with the top scanned bit.
        apply(64'h0000_0000_0000_8001, "R2");
        apply(64'h0000_0000_0001_8000, "R2");
        // R3: dense lower bits, highest at 9 gives 8.
        apply(64'h0000_0000_0000_03FE, "R3");

        // R1: reset during an override vector, then recovery.
        apply_in_reset(64'h0000_0000_0001_FFFF);
        apply(64'h0000_0000_0000_0100, "R3");

        // R7: input change between edges does not reach the outputs.
        apply(64'h0000_0000_0000_0040, "R7");
        @(posedge clk);
        #2;
        @(negedge clk);
        pend_vec = 64'h1;
        #1;
        check("R7", level_o, any_o, 4'd5, 1'b1);
        sb.push_back('{lvl: 4'd14, any: 1'b1, req: "R7", vec: 64'h1});

        // Random multi-bit vectors; half with the override bits cleared.
        for (int k = 0; k < 400; k++) begin
            v = {$urandom, $urandom};
            if (k % 2 == 0) begin
                v[0]  = 1'b0;
                v[16] = 1'b0;
                v[15:1] = v[15:1] >> ($urandom % 15);
                apply(v, "R3");
            end else begin
                apply(v, "R2");
            end
        end

        apply('0, "R4");
        repeat (4) @(posedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule